// File: doc/BRIEF.md
# Bus-Snooping Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous host I/O request port. A 24-bit counter steps down by one on every pulse of a slow time-base enable (nominally 32.768 kHz, so one count lasts about 30.52 µs). When a decrement brings it to zero, the block raises one timeout output, chosen by software: an interrupt pulse, an NMI pulse, or a board-reset level. The delay in microseconds is the reload value times 10^6 / 2^15, and the reload value out of reset gives the longest delay, about 512 s.

Software restarts the countdown in one of three ways. It can write any byte of the current-count register. It can write to the POST-code port at address 0x0080, if that kick source is enabled. It can read or write inside either of two address windows, if window kicking is enabled. Each window has its own base, and the two windows share a mask over the low four address bits, so a window spans 1 to 16 bytes. The registers are reached through an index port and a data port. These ports respond only after a short unlock sequence has opened configuration mode.

Top module: `bus_watchdog`

## Requirements
- R1: Reset state, with `rst` sampled high on a clock edge: reload = 0xFFFFFF, count = 0xFFFFFF, control = 0, all three timeout outputs low, configuration locked, `io_rdata` = 0.
- R2: Configuration opens after two consecutive writes of 0x5A to the index port (0x002E). It closes on a write of 0xA5 to the index port. While it is locked, data-port (0x002F) writes change nothing and data-port reads return 0.
- R3: Register map while open. The index selects the register; a data-port write stores the value, and a data-port read returns it on `io_rdata` in the cycle after the read strobe. Index 0–2 is reload bytes low to high. Index 6 is control, 4 bits: bit0 port-0x80 kick enable, bit1 window kick enable, bits 3:2 action. Index 7–8 is window 0 base, low byte then high byte. Index 9–10 is window 1 base. Index 11 is the mask, 4 bits. Unused upper bits read 0.
- R4: Each cycle with `tick` high and a nonzero count lowers the count by one. A zero count stays zero, and a reload of zero never times out.
- R5: In the cycle after the tick that takes the count from 1 to 0, the selected output goes high. Action 00 gives a one-cycle `wd_irq`. Action 01 gives a one-cycle `wd_nmi`. Action 1x sets `wd_reset`, which stays high until `rst`.
- R6: A data-port write to index 3, 4 or 5 reloads the count from the reload register.
- R7: With control bit0 set, any write to address 0x0080 reloads the count. A read of 0x0080 does not reload it, and neither does a write while bit0 is clear.
- R8: With control bit1 set, a read or a write at an address that matches either window base reloads the count. Address bits whose mask bit is 1 are ignored in the match. Misses reload nothing, and nothing reloads while bit1 is clear.
- R9: A reload in the same cycle as a tick wins: the count becomes the reload value and no timeout fires.
- R10: Index 3–5 read back the live count, low byte to high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base enable, 32.768 kHz nominal |
| io_addr | input | 16 | I/O request address |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Registered read data from the data port |
| wd_irq | output | 1 | Timeout interrupt pulse |
| wd_nmi | output | 1 | Timeout NMI pulse |
| wd_reset | output | 1 | Timeout reset level, held until `rst` |

## Verification
A counter that decrements on a wrong edge, or misses a reload, shows up at the ports through a count readback that is off by one or more counts one cycle after the access. A snoop that hits or misses wrongly leaves a count that differs from the reload value as soon as the next readback. A wrong action decode or a wrong firing cycle is visible in the cycle right after the final tick, where the bench samples all three outputs together. A broken lock state shows up as data-port reads that return nonzero, or as register contents that changed while locked once the block is reopened.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lock_e;

  // control register layout, bits 3:2 act, bit1 win_en, bit0 post_en
  typedef struct packed {
    logic [1:0] act;
    logic       win_en;
    logic       post_en;
  } ctrl_t;

  localparam logic [1:0] ACT_IRQ = 2'b00;
  localparam logic [1:0] ACT_NMI = 2'b01;

  localparam int unsigned CNT_W_DEF  = 24;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned MASK_W_DEF = 4;
  localparam int unsigned N_WIN      = 2;

endpackage

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
  import bwd_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned MASK_W   = MASK_W_DEF,
  parameter logic [15:0] IDX_PORT = 16'h002E,
  parameter logic [15:0] DAT_PORT = 16'h002F,
  parameter logic [7:0]  UNLOCK_B = 8'h5A,
  parameter logic [7:0]  LOCK_B   = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [7:0]           io_wdata,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [CNT_W-1:0]     count,
  output logic [7:0]           rdata,
  output logic [CNT_W-1:0]     reload,
  output ctrl_t                ctrl,
  output logic [ADDR_W-1:0]    win_base [N_WIN],
  output logic [MASK_W-1:0]    win_mask,
  output logic                 cnt_wr_kick
);

  localparam int unsigned NB     = (CNT_W + 7) / 8;
  localparam int unsigned AB     = (ADDR_W + 7) / 8;
  localparam int unsigned IX_RLD = 0;
  localparam int unsigned IX_CNT = IX_RLD + NB;
  localparam int unsigned IX_CTL = IX_CNT + NB;
  localparam int unsigned IX_WIN = IX_CTL + 1;
  localparam int unsigned IX_MSK = IX_WIN + N_WIN * AB;

  lock_e               lk_q;
  logic [7:0]          idx_q;
  logic [NB*8-1:0]     reload_q;
  ctrl_t               ctrl_q;
  logic [AB*8-1:0]     win_q [N_WIN];
  logic [MASK_W-1:0]   mask_q;
  logic [7:0]          rdata_q;
  logic [7:0]          rd_mux;
  logic [NB*8-1:0]     cnt_ext;
  logic                idx_wr;
  logic                dat_wr;
  logic                dat_rd;
  logic                open;

  assign open    = (lk_q == LK_OPEN);
  assign idx_wr  = io_wr && (io_addr == ADDR_W'(IDX_PORT));
  assign dat_wr  = io_wr && (io_addr == ADDR_W'(DAT_PORT));
  assign dat_rd  = io_rd && (io_addr == ADDR_W'(DAT_PORT));
  assign cnt_ext = (NB*8)'(count);

  // unlock sequencer and index register
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_q  <= LK_CLOSED;
      idx_q <= '0;
    end else if (idx_wr) begin
      unique case (lk_q)
        LK_CLOSED: lk_q <= (io_wdata == UNLOCK_B) ? LK_HALF : LK_CLOSED;
        LK_HALF:   lk_q <= (io_wdata == UNLOCK_B) ? LK_OPEN : LK_CLOSED;
        LK_OPEN: begin
          if (io_wdata == LOCK_B) lk_q <= LK_CLOSED;
          else                    idx_q <= io_wdata;
        end
        default:   lk_q <= LK_CLOSED;
      endcase
    end
  end

  // register file writes
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      ctrl_q   <= '0;
      mask_q   <= '0;
      for (int w = 0; w < N_WIN; w++) win_q[w] <= '0;
    end else if (dat_wr && open) begin
      for (int b = 0; b < NB; b++)
        if (idx_q == 8'(IX_RLD + b)) reload_q[b*8 +: 8] <= io_wdata;
      for (int w = 0; w < N_WIN; w++)
        for (int b = 0; b < AB; b++)
          if (idx_q == 8'(IX_WIN + w*AB + b)) win_q[w][b*8 +: 8] <= io_wdata;
      if (idx_q == 8'(IX_CTL)) ctrl_q <= ctrl_t'(io_wdata[3:0]);
      if (idx_q == 8'(IX_MSK)) mask_q <= io_wdata[MASK_W-1:0];
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (idx_q == 8'(IX_RLD + b)) rd_mux = reload_q[b*8 +: 8];
      if (idx_q == 8'(IX_CNT + b)) rd_mux = cnt_ext[b*8 +: 8];
    end
    for (int w = 0; w < N_WIN; w++)
      for (int b = 0; b < AB; b++)
        if (idx_q == 8'(IX_WIN + w*AB + b)) rd_mux = win_q[w][b*8 +: 8];
    if (idx_q == 8'(IX_CTL)) rd_mux = 8'(ctrl_q);
    if (idx_q == 8'(IX_MSK)) rd_mux = 8'(mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata_q <= '0;
    else if (dat_rd && open)  rdata_q <= rd_mux;
    else                      rdata_q <= '0;
  end

  assign cnt_wr_kick = dat_wr && open &&
                       (idx_q >= 8'(IX_CNT)) && (idx_q < 8'(IX_CNT + NB));

  assign rdata    = rdata_q;
  assign reload   = reload_q[CNT_W-1:0];
  assign ctrl     = ctrl_q;
  assign win_mask = mask_q;
  for (genvar w = 0; w < N_WIN; w++) begin : g_win_out
    assign win_base[w] = win_q[w][ADDR_W-1:0];
  end

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!open && dat_wr) |=> ($stable(reload_q) && $stable(ctrl_q) && $stable(mask_q)));

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!open) |=> (rdata_q == 8'h00));

endmodule

// File: rtl/bwd_kick_snoop.sv
module bwd_kick_snoop
  import bwd_pkg::*;
#(
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned MASK_W    = MASK_W_DEF,
  parameter logic [15:0] POST_PORT = 16'h0080
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] win_base [N_WIN],
  input  logic [MASK_W-1:0] win_mask,
  input  logic              cnt_wr_kick,
  output logic              kick
);

  localparam int unsigned HI_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0] care;
  logic [N_WIN-1:0]  win_hit;
  logic              post_hit;

  assign care = ~{{HI_W{1'b0}}, win_mask};

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    assign win_hit[w] = (((io_addr ^ win_base[w]) & care) == '0);
  end

  assign post_hit = io_wr && (io_addr == ADDR_W'(POST_PORT));

  assign kick = cnt_wr_kick
              | (ctrl.post_en && post_hit)
              | (ctrl.win_en && (io_rd || io_wr) && (|win_hit));

endmodule

// File: rtl/bwd_down_counter.sv
module bwd_down_counter
  import bwd_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] reload,
  input  logic [1:0]       act,
  output logic [CNT_W-1:0] count,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, nmi_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      nmi_q <= 1'b0;
      if (kick) begin
        cnt_q <= reload;
      end else if (tick && (cnt_q != '0)) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          if (act == ACT_IRQ)      irq_q  <= 1'b1;
          else if (act == ACT_NMI) nmi_q  <= 1'b1;
          else                     hold_q <= 1'b1;
        end
      end
    end
  end

  assign count = cnt_q;
  assign irq_o = irq_q;
  assign nmi_o = nmi_q;
  assign rst_o = hold_q;

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !kick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R4
  cnt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!kick && cnt_q == '0) |=> (cnt_q == '0));

  // R9
  kick_prio_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == $past(reload)));

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q || nmi_q) |=> !(irq_q || nmi_q));

  // R5
  fire_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_q || nmi_q) |-> ($past(tick) && !$past(kick) && $past(cnt_q) == ONE));

  // R5
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> hold_q);

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bwd_pkg::*;
#(
  parameter int unsigned CNT_W     = CNT_W_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned MASK_W    = MASK_W_DEF,
  parameter logic [15:0] IDX_PORT  = 16'h002E,
  parameter logic [15:0] DAT_PORT  = 16'h002F,
  parameter logic [15:0] POST_PORT = 16'h0080
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic              wd_irq,
  output logic              wd_nmi,
  output logic              wd_reset
);

  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  reload;
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] win_base [N_WIN];
  logic [MASK_W-1:0] win_mask;
  logic              cnt_wr_kick;
  logic              kick;

  bwd_cfg_regs #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W),
    .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
  ) cfg_i (
    .clk(clk), .rst(rst),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .count(count), .rdata(io_rdata), .reload(reload), .ctrl(ctrl),
    .win_base(win_base), .win_mask(win_mask), .cnt_wr_kick(cnt_wr_kick)
  );

  bwd_kick_snoop #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W), .POST_PORT(POST_PORT)
  ) snoop_i (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .ctrl(ctrl),
    .win_base(win_base), .win_mask(win_mask),
    .cnt_wr_kick(cnt_wr_kick), .kick(kick)
  );

  bwd_down_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick),
    .reload(reload), .act(ctrl.act), .count(count),
    .irq_o(wd_irq), .nmi_o(wd_nmi), .rst_o(wd_reset)
  );

  // R7
  post_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && io_addr == ADDR_W'(POST_PORT) && !ctrl.win_en && !cnt_wr_kick)
      |-> !kick);

endmodule

// File: tb/bus_watchdog_tb.sv
module bus_watchdog_tb_top;

  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic        wd_irq, wd_nmi, wd_reset;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic s_irq, s_nmi, s_rst;

  always #10 clk = ~clk;

  bus_watchdog dut_i (
    .clk(clk), .rst(rst), .tick(tick),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .wd_irq(wd_irq), .wd_nmi(wd_nmi), .wd_reset(wd_reset)
  );

  // {read, index, write data, expected}
  localparam int NV = 22;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'd0,  8'h34, 8'h00}, {1'b0, 8'd1,  8'h12, 8'h00},
    {1'b0, 8'd2,  8'h00, 8'h00}, {1'b1, 8'd0,  8'h00, 8'h34},
    {1'b1, 8'd1,  8'h00, 8'h12}, {1'b1, 8'd2,  8'h00, 8'h00},
    {1'b0, 8'd6,  8'hFF, 8'h00}, {1'b1, 8'd6,  8'h00, 8'h0F},
    {1'b0, 8'd6,  8'h00, 8'h00}, {1'b1, 8'd6,  8'h00, 8'h00},
    {1'b0, 8'd7,  8'h00, 8'h00}, {1'b0, 8'd8,  8'h03, 8'h00},
    {1'b0, 8'd9,  8'h10, 8'h00}, {1'b0, 8'd10, 8'h04, 8'h00},
    {1'b0, 8'd11, 8'hFF, 8'h00}, {1'b1, 8'd11, 8'h00, 8'h0F},
    {1'b0, 8'd11, 8'h03, 8'h00}, {1'b1, 8'd11, 8'h00, 8'h03},
    {1'b1, 8'd7,  8'h00, 8'h00}, {1'b1, 8'd8,  8'h00, 8'h03},
    {1'b1, 8'd9,  8'h00, 8'h10}, {1'b1, 8'd10, 8'h00, 8'h04}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] v);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic unlock();
    io_write(IDX, 8'h5A);
    io_write(IDX, 8'h5A);
  endtask

  task automatic cfg_write(input logic [7:0] ix, input logic [7:0] d);
    io_write(IDX, ix);
    io_write(DAT, d);
  endtask

  task automatic cfg_read(input logic [7:0] ix, output logic [7:0] v);
    io_write(IDX, ix);
    io_read(DAT, v);
  endtask

  task automatic read_count(output logic [23:0] c);
    logic [7:0] b0, b1, b2;
    cfg_read(8'd3, b0);
    cfg_read(8'd4, b1);
    cfg_read(8'd5, b2);
    c = {b2, b1, b0};
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    s_irq = wd_irq; s_nmi = wd_nmi; s_rst = wd_reset;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [23:0] c;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset outputs, R2 locked reads
    check("R1 outputs", 32'({wd_irq, wd_nmi, wd_reset}), 32'd0);
    check("R1 rdata", 32'(io_rdata), 32'd0);
    io_read(DAT, v);
    check("R2 locked read", 32'(v), 32'd0);
    io_write(IDX, 8'h00);
    io_write(DAT, 8'h12);
    unlock();
    cfg_read(8'd0, v);
    check("R2 locked write ignored", 32'(v), 32'hFF);
    cfg_read(8'd1, v);
    check("R1 reload mid", 32'(v), 32'hFF);
    cfg_read(8'd2, v);
    check("R1 reload high", 32'(v), 32'hFF);
    read_count(c);
    check("R1 count", 32'(c), 32'hFFFFFF);
    cfg_read(8'd6, v);
    check("R1 control", 32'(v), 32'd0);

    // R3 register map walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        cfg_read(VEC[i][23:16], v);
        check("R3 readback", 32'(v), 32'(VEC[i][7:0]));
      end else begin
        cfg_write(VEC[i][23:16], VEC[i][15:8]);
      end
    end

    // R6 kick by current-value write, R4 countdown, R10 live count
    cfg_write(8'd0, 8'h03); cfg_write(8'd1, 8'h00); cfg_write(8'd2, 8'h00);
    cfg_write(8'd3, 8'h00);
    read_count(c);
    check("R6 reload on count write", 32'(c), 32'd3);
    pulse_tick();
    read_count(c);
    check("R10 live count", 32'(c), 32'd2);
    pulse_tick();
    check("R5 no early irq", 32'(s_irq), 32'd0);
    pulse_tick();
    check("R5 irq pulse", 32'({s_irq, s_nmi, s_rst}), 32'b100);
    @(negedge clk);
    check("R5 irq single cycle", 32'(wd_irq), 32'd0);
    read_count(c);
    check("R4 reached zero", 32'(c), 32'd0);
    for (int i = 0; i < 3; i++) begin
      pulse_tick();
      check("R4 no refire at zero", 32'(s_irq), 32'd0);
    end
    read_count(c);
    check("R4 no wrap", 32'(c), 32'd0);
    cfg_write(8'd4, 8'h99);
    read_count(c);
    check("R6 reload via mid byte", 32'(c), 32'd3);

    // R7 POST port kick
    pulse_tick(); pulse_tick();
    io_write(16'h0080, 8'h11);
    read_count(c);
    check("R7 disabled post write", 32'(c), 32'd1);
    cfg_write(8'd6, 8'h01);
    io_write(16'h0080, 8'h22);
    read_count(c);
    check("R7 enabled post write", 32'(c), 32'd3);
    pulse_tick();
    io_read(16'h0080, v);
    read_count(c);
    check("R7 post read ignored", 32'(c), 32'd2);

    // R9 reload beats tick
    pulse_tick();
    io_addr = 16'h0080; io_wdata = 8'h33; io_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; tick = 1'b0;
    check("R9 no fire on kick+tick", 32'(wd_irq), 32'd0);
    read_count(c);
    check("R9 reload wins", 32'(c), 32'd3);

    // R8 windows: win0 0x0300 mask 3, win1 0x0410
    cfg_write(8'd6, 8'h02);
    io_write(16'h0080, 8'h00);
    pulse_tick();
    read_count(c);
    check("R7 post off with windows only", 32'(c), 32'd2);
    io_read(16'h0302, v);
    read_count(c);
    check("R8 window0 read hit", 32'(c), 32'd3);
    pulse_tick();
    io_write(16'h0304, 8'h00);
    read_count(c);
    check("R8 window0 miss", 32'(c), 32'd2);
    io_write(16'h0413, 8'h00);
    read_count(c);
    check("R8 window1 masked write hit", 32'(c), 32'd3);
    pulse_tick();
    cfg_write(8'd6, 8'h00);
    io_read(16'h0300, v);
    read_count(c);
    check("R8 windows disabled", 32'(c), 32'd2);

    // R5 NMI action
    cfg_write(8'd6, 8'h04);
    cfg_write(8'd3, 8'h00);
    pulse_tick(); pulse_tick(); pulse_tick();
    check("R5 nmi pulse", 32'({s_irq, s_nmi, s_rst}), 32'b010);
    @(negedge clk);
    check("R5 nmi single cycle", 32'(wd_nmi), 32'd0);

    // R5 reset action held
    cfg_write(8'd6, 8'h08);
    cfg_write(8'd3, 8'h00);
    pulse_tick(); pulse_tick(); pulse_tick();
    check("R5 reset asserted", 32'({s_irq, s_nmi, s_rst}), 32'b001);
    cfg_write(8'd3, 8'h00);
    repeat (5) @(negedge clk);
    check("R5 reset held after kick", 32'(wd_reset), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R5 reset cleared by rst", 32'(wd_reset), 32'd0);
    check("R1 rdata after rst", 32'(io_rdata), 32'd0);

    // R2 lock byte closes access
    unlock();
    cfg_write(8'd0, 8'h55);
    io_write(IDX, 8'hA5);
    io_write(DAT, 8'h77);
    io_read(DAT, v);
    check("R2 read after lock", 32'(v), 32'd0);
    unlock();
    cfg_read(8'd0, v);
    check("R2 write after lock ignored", 32'(v), 32'h55);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule